// File: doc/BRIEF.md
# Double-Column Hit Address Encoder

This block drains the latched hit pattern of one pixel double column, which is 512 rows of two pixels each. A hit frame is captured into an internal hit register. The block then shows the address of the pending hit with the highest priority, together with a valid flag. Each read strobe takes that hit out of the register, so repeated strobes yield every hit address exactly once, in ascending order. When no hit is left, the valid flag is low and the register stays still.

Addresses are 10 bits wide and follow the rule address = 2·row + column. The left column is column 0 and the right column is column 1. The lowest address has the highest priority. A new frame is accepted only while the register is empty, so two frames never mix.

The encoder is built as a two-level tree: one level finds the lowest hit in each group, and the second finds the lowest group that holds a hit. The address and valid outputs are combinational outputs of the hit register.

Top module: `dcol_hit_encoder`

## Requirements
- R1: While reset is low, and after reset is released, valid is 0 and addr is 0 until a frame is loaded.
- R2: A load pulse while valid is 0 captures hit_left and hit_right at the clock edge, and valid is 1 from that edge onward if any bit was set.
- R3: While valid is 1, addr is the lowest address whose hit bit is still pending.
- R4: Bit r of hit_left maps to address 2·r, and bit r of hit_right maps to address 2·r+1.
- R5: A sel pulse while valid is 1 removes exactly the hit at the shown addr at the next clock edge, and the next pending address appears after that edge.
- R6: After the last pending hit is removed, valid is 0 and addr is 0.
- R7: A sel pulse while valid is 0 has no effect: valid stays 0 and a following load behaves normally.
- R8: A load pulse while valid is 1 is ignored: the pending hits and the shown addr are unchanged.
- R9: A frame with all 1024 pixels hit is drained in exactly 1024 strobes, with addresses 0 through 1023 in order.
- R10: While valid is 1 and sel is 0, addr and valid hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture a new hit frame (honoured only while valid is 0) |
| hit_left | input | 512 | Left-column hit bits, one per row |
| hit_right | input | 512 | Right-column hit bits, one per row |
| sel | input | 1 | Read strobe: remove the shown hit |
| addr | output | 10 | Address of the highest-priority pending hit |
| valid | output | 1 | At least one hit is pending |

## Verification
The bench aims at several boundaries. The group boundary at addresses 31 and 32 would be skipped or reordered by a faulty second-level encoder. The first and last rows and the row pair 510/511 expose a swapped column mapping, which would show odd addresses before even ones. A load issued in the middle of a drain would corrupt the remaining sequence if it were not blocked. A strobe on an empty register would expose a block that wrongly raises valid or disturbs the next frame. The fully hit frame catches a clear mask that removes too many bits or too few, because either fault breaks the 0 to 1023 sequence.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
  typedef enum logic [0:0] {COL_LEFT = 1'b0, COL_RIGHT = 1'b1} dcp_col_e;

  // linear pixel index of a row/column pair
  function automatic int pix_index(input int row, input dcp_col_e col);
    return 2 * row + int'(col);
  endfunction
endpackage

// File: rtl/dcp_prio_tree.sv
module dcp_prio_tree #(
  parameter int N  = 1024,
  parameter int GW = 32
) (
  input  logic [N-1:0]         vec,
  output logic                 vld,
  output logic [$clog2(N)-1:0] idx
);
  localparam int NG  = N / GW;
  localparam int LW  = $clog2(GW);
  localparam int GSW = $clog2(NG);

  logic [NG-1:0] grp_v;
  logic [LW-1:0] grp_i [NG];

  genvar g;
  generate
    for (g = 0; g < NG; g++) begin : g_leaf
      logic [GW-1:0] slice;
      assign slice    = vec[g*GW +: GW];
      assign grp_v[g] = |slice;
      always_comb begin
        grp_i[g] = '0;
        for (int i = GW - 1; i >= 0; i--) begin
          if (slice[i]) grp_i[g] = LW'(i);
        end
      end
    end
  endgenerate

  logic [GSW-1:0] win_g;
  always_comb begin
    win_g = '0;
    for (int k = NG - 1; k >= 0; k--) begin
      if (grp_v[k]) win_g = GSW'(k);
    end
  end

  assign vld = |grp_v;
  assign idx = vld ? {win_g, grp_i[win_g]} : '0;
endmodule

// File: rtl/dcp_clear_dec.sv
module dcp_clear_dec #(
  parameter int N  = 1024,
  parameter int AW = 10
) (
  input  logic          fire,
  input  logic [AW-1:0] idx,
  output logic [N-1:0]  mask
);
  genvar b;
  generate
    for (b = 0; b < N; b++) begin : g_bit
      assign mask[b] = fire && (idx == AW'(b));
    end
  endgenerate
endmodule

// File: rtl/dcp_hit_store.sv
module dcp_hit_store
  import dcp_pkg::*;
#(
  parameter int ROWS = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ROWS-1:0]   hit_left,
  input  logic [ROWS-1:0]   hit_right,
  input  logic              fire,
  input  logic [2*ROWS-1:0] clr_mask,
  output logic [2*ROWS-1:0] hits,
  output logic              any
);
  localparam int N = 2 * ROWS;

  logic [N-1:0] frame;
  logic [N-1:0] hits_nxt;
  logic         take;
  logic         en;

  genvar r;
  generate
    for (r = 0; r < ROWS; r++) begin : g_row
      assign frame[pix_index(r, COL_LEFT)]  = hit_left[r];
      assign frame[pix_index(r, COL_RIGHT)] = hit_right[r];
    end
  endgenerate

  assign any  = |hits;
  assign take = load && !any;
  assign en   = take || fire;

  always_comb begin
    hits_nxt = hits;
    if (take)      hits_nxt = frame;
    else if (fire) hits_nxt = hits & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  hits <= '0;
    else if (en) hits <= hits_nxt;
  end

  // R5
  one_removed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> $countones(hits) == $countones($past(hits)) - 1);

  // R8
  busy_load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any && load && !fire) |=> $stable(hits));

  // R7
  idle_stays_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any && !load) |=> (hits == '0));
endmodule

// File: rtl/dcol_hit_encoder.sv
module dcol_hit_encoder #(
  parameter int ROWS = 512,
  parameter int GW   = 32,
  localparam int N   = 2 * ROWS,
  localparam int AW  = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [ROWS-1:0] hit_left,
  input  logic [ROWS-1:0] hit_right,
  input  logic            sel,
  output logic [AW-1:0]   addr,
  output logic            valid
);
  logic [N-1:0]  hits;
  logic [N-1:0]  clr_mask;
  logic          any;
  logic          fire;
  logic          tree_vld;
  logic [AW-1:0] tree_idx;

  assign fire = sel && any;

  dcp_hit_store #(.ROWS(ROWS)) u_store (
    .clk(clk), .rst_n(rst_n), .load(load),
    .hit_left(hit_left), .hit_right(hit_right),
    .fire(fire), .clr_mask(clr_mask), .hits(hits), .any(any)
  );

  dcp_prio_tree #(.N(N), .GW(GW)) u_tree (
    .vec(hits), .vld(tree_vld), .idx(tree_idx)
  );

  dcp_clear_dec #(.N(N), .AW(AW)) u_clr (
    .fire(fire), .idx(tree_idx), .mask(clr_mask)
  );

  assign addr  = tree_idx;
  assign valid = tree_vld;

  // R3
  shown_is_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> hits[addr]);

  // R3
  nothing_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((hits & ~({N{1'b1}} << addr)) == '0));

  // R6
  empty_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (addr == '0));

  // R10
  hold_without_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !sel) |=> (valid && $stable(addr)));
endmodule

// File: tb/dcol_hit_encoder_test.sv
module dcol_hit_encoder_test;
  localparam int ROWS = 512;
  localparam int N    = 2 * ROWS;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            load = 1'b0;
  logic            sel = 1'b0;
  logic [ROWS-1:0] hit_left = '0;
  logic [ROWS-1:0] hit_right = '0;
  logic [9:0]      addr;
  logic            valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dcol_hit_encoder uut (
    .clk(clk), .rst_n(rst_n), .load(load), .hit_left(hit_left),
    .hit_right(hit_right), .sel(sel), .addr(addr), .valid(valid)
  );

  // each row: four sorted, distinct addresses
  localparam logic [9:0] VEC [8][4] = '{
    '{10'd0,   10'd1,   10'd2,    10'd3},
    '{10'd31,  10'd32,  10'd63,   10'd64},
    '{10'd510, 10'd511, 10'd512,  10'd513},
    '{10'd1020,10'd1021,10'd1022, 10'd1023},
    '{10'd0,   10'd511, 10'd512,  10'd1023},
    '{10'd5,   10'd100, 10'd700,  10'd900},
    '{10'd1,   10'd2,   10'd1022, 10'd1023},
    '{10'd33,  10'd34,  10'd96,   10'd97}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(input int a);
    if (a[0]) hit_right[a >> 1] = 1'b1;
    else      hit_left[a >> 1]  = 1'b1;
  endtask

  task automatic pulse_load;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    hit_left = '0;
    hit_right = '0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(valid == 1'b0, "R1 valid in reset", valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid == 1'b0 && addr == 0, "R1 valid after reset", valid, 0);

    // table walk: R2 R3 R4 R5 R6
    for (int v = 0; v < 8; v++) begin
      for (int k = 0; k < 4; k++) put(VEC[v][k]);
      @(negedge clk);
      pulse_load();
      check(valid == 1'b1, "R2 valid after load", valid, 1);
      for (int k = 0; k < 4; k++) begin
        check(valid && addr == VEC[v][k], "R3 R5 walk order", addr, VEC[v][k]);
        sel = 1'b1;
        @(negedge clk);
      end
      sel = 1'b0;
      check(valid == 1'b0 && addr == 0, "R6 empty after last", valid, 0);
    end

    // R4: column mapping, single pixels
    hit_right[0] = 1'b1;
    pulse_load();
    check(addr == 1, "R4 right row0", addr, 1);
    sel = 1'b1; @(negedge clk); sel = 1'b0;
    hit_left[511] = 1'b1;
    pulse_load();
    check(addr == 1022, "R4 left row511", addr, 1022);
    sel = 1'b1; @(negedge clk); sel = 1'b0;
    check(valid == 1'b0, "R6 empty after single", valid, 0);

    // R10 and R8: hold without sel, busy load ignored
    put(5); put(100);
    pulse_load();
    repeat (3) @(negedge clk);
    check(valid && addr == 5, "R10 hold without sel", addr, 5);
    put(0);
    pulse_load();
    check(valid && addr == 5, "R8 busy load ignored", addr, 5);
    sel = 1'b1; @(negedge clk);
    check(valid && addr == 100, "R8 remaining hit", addr, 100);
    @(negedge clk); sel = 1'b0;
    check(valid == 1'b0, "R8 no extra hit", valid, 0);

    // R7: strobes on empty register
    sel = 1'b1;
    repeat (3) @(negedge clk);
    sel = 1'b0;
    check(valid == 1'b0 && addr == 0, "R7 sel when empty", valid, 0);
    put(700);
    pulse_load();
    check(valid && addr == 700, "R7 load after empty sel", addr, 700);
    sel = 1'b1; @(negedge clk); sel = 1'b0;

    // R9: full frame
    hit_left = '1;
    hit_right = '1;
    pulse_load();
    sel = 1'b1;
    for (int a = 0; a < N; a++) begin
      if (!(valid && addr == a)) check(1'b0, "R9 full frame order", addr, a);
      @(negedge clk);
    end
    checks++;
    sel = 1'b0;
    check(valid == 1'b0, "R9 full frame drained", valid, 0);

    // R1: reset in the middle of a drain
    put(3); put(9);
    pulse_load();
    rst_n = 1'b0;
    #1;
    check(valid == 1'b0, "R1 async reset clears", valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid == 1'b0 && addr == 0, "R1 empty after reset", valid, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule